// File: doc/BRIEF.md
# GPIO Register Bank

This block stores the control state of a bank of general-purpose I/O pins and exposes it through a 32-bit register port with a byte address. Each pin owns two configuration words placed at a fixed stride. The words select the pin function, direction, output level, input-sense gating and weak-pull code. A small bitmap records which pins firmware has released for general use. A global word selects which of two system interrupt lines the bank's combined interrupt uses.

The block drives each pin's output enable and output value, and it presents each pin's pull code to the pad. It passes every pad input through a two-flop synchroniser and returns the result inside the first configuration word. That read-only level shares the word with writable control bits, so software can read-modify-write the word safely. Interrupt detection, the pads and any bus bridge sit outside this block.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pin's first word reads 0x00000004 and its second word reads 0x00000004. In the first word this means direction is input, the pin is in native mode and the output level is 0. In the second word it means input sensing is disabled and the pull code is 0. After reset, pin_oe_o, pin_out_o, pin_pull_o, irq_sel_o and rd_data_o are all zero.
- R2: The byte offsets 0x00, 0x04 and 0x08 return the ownership bitmap, which comes from the OWN_INIT parameter. Pin 32*w+b appears in bit b of word w. A 1 bit means the pin is usable as GPIO. Bits above the last pin read 0, and writes to these words are ignored.
- R3: Pin n's first word is at 0x100+8n and its second word is at 0x104+8n. In the first word only bits 31 (output level), 2 (direction, 1 means input) and 0 (use-select, 1 means GPIO) are writable. In the second word only bits 2 (sense disable) and 1:0 (pull code) are writable. All other bits read 0.
- R4: pin_oe_o[n] is 1 exactly when pin n has use-select 1 and direction 0. pin_out_o[n] equals the output-level bit while the pin drives, and is 0 otherwise. Both follow a write in the cycle after the write.
- R5: Bit 30 of the first word returns the pad input after a two-flop synchroniser. It reads 0 while bit 2 of the second word is 1.
- R6: Writes to bit 30 of the first word are ignored. Writing a word back unchanged keeps the control bits and leaves the sampled level as it is.
- R7: Offset 0x7C holds the interrupt-line select in bit 0, which drives irq_sel_o. Its other bits read 0.
- R8: A read of any unmapped offset returns 0. A write to an unmapped offset changes no state. Offsets past the last pin's words count as unmapped.
- R9: Read data appears on rd_data_o at the clock edge that accepts the read. It holds until the next read, including across writes and idle cycles.
- R10: pin_pull_o[2n+1:2n] equals bits 1:0 of pin n's second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | ADDR_W (10) | Byte address; bits 1:0 ignored |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| pin_in_i | input | NUM_PINS | Pad input levels |
| pin_oe_o | output | NUM_PINS | Per-pin output enable |
| pin_out_o | output | NUM_PINS | Per-pin output value |
| pin_pull_o | output | 2*NUM_PINS | Per-pin weak-pull code |
| irq_sel_o | output | 1 | Interrupt line select |

## Verification
The bench builds the block with 94 pins. This gives three bitmap words, the last of which is only partly filled, and leaves the address space just past pin 93 unmapped. OWN_INIT is set to a distinct 94-bit pattern, so each bitmap word and the zero padding above pin 93 can be told apart. With these values the first and last pins and a pin in the middle can all be reached. The bench also covers the sense-gated sampled level and the boundary between the last pin's words and unmapped space.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned GLB_OFS    = 32'h7C;
  localparam int unsigned CFG_BASE   = 32'h100;
  localparam int unsigned CFG_STRIDE = 8;

  // config word A bit positions
  localparam int unsigned A_OUT = 31;
  localparam int unsigned A_LVL = 30;
  localparam int unsigned A_DIR = 2;
  localparam int unsigned A_USE = 0;
  // config word B bit positions
  localparam int unsigned B_SDIS = 2;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_OWN  = 2'd1,
    HIT_GLB  = 2'd2,
    HIT_CFG  = 2'd3
  } hit_e;
endpackage

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 94,
  parameter int unsigned OWN_WORDS = 3,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned PIN_W     = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_e              hit_o,
  output logic [PIN_W-1:0]  pin_idx_o,
  output logic              cfg_hi_o,
  output logic [ADDR_W-3:0] word_o
);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] GLB_A = ADDR_W'(GLB_OFS);

  logic [ADDR_W-1:0] cfg_off;
  logic [ADDR_W-4:0] pin_full;

  assign cfg_off   = addr_i - CFG_A;
  assign pin_full  = cfg_off[ADDR_W-1:3];
  assign pin_idx_o = PIN_W'(pin_full);
  assign cfg_hi_o  = addr_i[2];
  assign word_o    = addr_i[ADDR_W-1:2];

  always_comb begin
    if (word_o < (ADDR_W-2)'(OWN_WORDS))
      hit_o = HIT_OWN;
    else if (word_o == GLB_A[ADDR_W-1:2])
      hit_o = HIT_GLB;
    else if ((addr_i >= CFG_A) && (pin_full < (ADDR_W-3)'(NUM_PINS)))
      hit_o = HIT_CFG;
    else
      hit_o = HIT_NONE;
  end

  // R3: a config hit always names an existing pin
  always_comb begin
    if (hit_o == HIT_CFG)
      a_cfg_pin_range_r3: assert (32'(pin_idx_o) < NUM_PINS);
  end
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              pin_i,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o,
  output logic              oe_o,
  output logic              out_o,
  output logic [1:0]        pull_o
);
  logic       out_q, dir_q, use_q, sdis_q;
  logic [1:0] pull_q;
  logic [1:0] sync_q;
  logic       lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      dir_q <= 1'b1;
      use_q <= 1'b0;
    end else if (wr_a_i) begin
      out_q <= wdata_i[A_OUT];
      dir_q <= wdata_i[A_DIR];
      use_q <= wdata_i[A_USE];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdis_q <= 1'b1;
      pull_q <= 2'b00;
    end else if (wr_b_i) begin
      sdis_q <= wdata_i[B_SDIS];
      pull_q <= wdata_i[1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], pin_i};
  end

  assign lvl      = sync_q[1] & ~sdis_q;
  assign word_a_o = {out_q, lvl, 27'b0, dir_q, 1'b0, use_q};
  assign word_b_o = {29'b0, sdis_q, pull_q};
  assign oe_o     = use_q & ~dir_q;
  assign out_o    = out_q & oe_o;
  assign pull_o   = pull_q;

  p_oe_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_a_i |=> $stable(oe_o) && $stable(out_o));

  p_sync_lvl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sdis_q && $past(!sdis_q) && !$past(wr_b_i)) |-> (word_a_o[A_LVL] == $past(sync_q[0])));

  p_lvl_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_b_i && wdata_i[B_SDIS]) |=> !word_a_o[A_LVL]);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned          NUM_PINS = 94,
  parameter logic [NUM_PINS-1:0]  OWN_INIT = '1,
  localparam int unsigned         ADDR_W   = $clog2(CFG_BASE + CFG_STRIDE*NUM_PINS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [WORD_W-1:0]     req_wdata_i,
  output logic [WORD_W-1:0]     rd_data_o,
  input  logic [NUM_PINS-1:0]   pin_in_i,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [NUM_PINS-1:0]   pin_out_o,
  output logic [2*NUM_PINS-1:0] pin_pull_o,
  output logic                  irq_sel_o
);
  localparam int unsigned OWN_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W     = OWN_WORDS * WORD_W;
  localparam int unsigned PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [PAD_W-1:0] OWN_PAD = PAD_W'(OWN_INIT);

  hit_e              hit;
  logic [PIN_W-1:0]  pin_idx;
  logic              cfg_hi;
  logic [ADDR_W-3:0] word;
  logic              wr_en, rd_en;

  gpio_bank_decode #(
    .NUM_PINS (NUM_PINS),
    .OWN_WORDS(OWN_WORDS),
    .ADDR_W   (ADDR_W),
    .PIN_W    (PIN_W)
  ) decode_i (
    .addr_i   (req_addr_i),
    .hit_o    (hit),
    .pin_idx_o(pin_idx),
    .cfg_hi_o (cfg_hi),
    .word_o   (word)
  );

  assign wr_en = req_valid_i & req_write_i;
  assign rd_en = req_valid_i & ~req_write_i;

  logic [WORD_W-1:0] word_a [NUM_PINS];
  logic [WORD_W-1:0] word_b [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic sel;
    assign sel = wr_en && (hit == HIT_CFG) && (pin_idx == PIN_W'(p));
    gpio_pin_cell cell_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_a_i  (sel & ~cfg_hi),
      .wr_b_i  (sel & cfg_hi),
      .wdata_i (req_wdata_i),
      .pin_i   (pin_in_i[p]),
      .word_a_o(word_a[p]),
      .word_b_o(word_b[p]),
      .oe_o    (pin_oe_o[p]),
      .out_o   (pin_out_o[p]),
      .pull_o  (pin_pull_o[2*p +: 2])
    );
  end

  logic glb_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      glb_q <= 1'b0;
    else if (wr_en && hit == HIT_GLB) glb_q <= req_wdata_i[0];
  end
  assign irq_sel_o = glb_q;

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (hit)
      HIT_OWN: begin
        for (int w = 0; w < OWN_WORDS; w++)
          if (word == (ADDR_W-2)'(w)) rd_mux = OWN_PAD[w*WORD_W +: WORD_W];
      end
      HIT_GLB: rd_mux = {31'b0, glb_q};
      HIT_CFG: rd_mux = cfg_hi ? word_b[pin_idx] : word_a[pin_idx];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_data_o <= '0;
    else if (rd_en) rd_data_o <= rd_mux;
  end

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && hit == HIT_NONE) |=> (rd_data_o == '0));

  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rd_data_o));

  p_irq_sel_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && hit == HIT_GLB) |=> $stable(irq_sel_o));
endmodule

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
  localparam int unsigned NP = 94;
  localparam logic [NP-1:0] TB_OWN = {30'h2BCD_1234, 32'hDEAD_BEEF, 32'h0F0F_F0F0};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [9:0]        req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic [31:0]       rd_data;
  logic [NP-1:0]     pin_in = '0;
  logic [NP-1:0]     pin_oe, pin_out;
  logic [2*NP-1:0]   pin_pull;
  logic              irq_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .OWN_INIT(TB_OWN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_data_o(rd_data), .pin_in_i(pin_in),
    .pin_oe_o(pin_oe), .pin_out_o(pin_out),
    .pin_pull_o(pin_pull), .irq_sel_o(irq_sel)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h000, 32'h0,         32'h0F0F_F0F0, 8'd2},  // R2 word 0
    '{1'b0, 10'h004, 32'h0,         32'hDEAD_BEEF, 8'd2},  // R2 word 1
    '{1'b0, 10'h008, 32'h0,         32'h2BCD_1234, 8'd2},  // R2 word 2, padding zero
    '{1'b1, 10'h004, 32'h0,         32'h0,         8'd2},
    '{1'b0, 10'h004, 32'h0,         32'hDEAD_BEEF, 8'd2},  // R2 write ignored
    '{1'b0, 10'h100, 32'h0,         32'h0000_0004, 8'd1},  // R1 pin 0 word A
    '{1'b0, 10'h104, 32'h0,         32'h0000_0004, 8'd1},  // R1 pin 0 word B
    '{1'b1, 10'h110, 32'hFFFF_FFFF, 32'h0,         8'd3},
    '{1'b0, 10'h110, 32'h0,         32'h8000_0005, 8'd3},  // R3 pin 2 mask
    '{1'b1, 10'h2EC, 32'hFFFF_FFFF, 32'h0,         8'd3},
    '{1'b0, 10'h2EC, 32'h0,         32'h0000_0007, 8'd3},  // R3 pin 61 word B mask
    '{1'b1, 10'h07C, 32'hFFFF_FFFF, 32'h0,         8'd7},
    '{1'b0, 10'h07C, 32'h0,         32'h0000_0001, 8'd7},  // R7
    '{1'b0, 10'h00C, 32'h0,         32'h0,         8'd8},  // R8 gap after bitmap
    '{1'b0, 10'h3F0, 32'h0,         32'h0,         8'd8},  // R8 past last pin
    '{1'b1, 10'h3F0, 32'hFFFF_FFFF, 32'h0,         8'd8},
    '{1'b1, 10'h050, 32'hFFFF_FFFF, 32'h0,         8'd8},
    '{1'b0, 10'h050, 32'h0,         32'h0,         8'd8},  // R8
    '{1'b0, 10'h3E8, 32'h0,         32'h0000_0004, 8'd8},  // R8 pin 93 untouched
    '{1'b0, 10'h3EC, 32'h0,         32'h0000_0004, 8'd3}   // R3 last pin word B
  };

  task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset outputs
    check("R1 oe",   192'(pin_oe),   192'(0));
    check("R1 out",  192'(pin_out),  192'(0));
    check("R1 pull", 192'(pin_pull), 192'(0));
    check("R1 irq",  192'(irq_sel),  192'(0));
    check("R1 rd",   192'(rd_data),  192'(0));

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) do_write(VECS[i].addr, VECS[i].data);
      else begin
        do_read(VECS[i].addr, d);
        check($sformatf("R%0d vec%0d", VECS[i].req, i), 192'(d), 192'(VECS[i].exp));
      end
    end

    // R7 output pin, R10 pull code of pin 61
    check("R7 irq_sel", 192'(irq_sel), 192'(1));
    check("R10 pull61", 192'(pin_pull[123:122]), 192'(3));
    check("R10 others", 192'(pin_pull & ~(188'(3) << 122)), 192'(0));

    // R4: pin 2 is GPIO input (no drive); pin 5 driven high
    check("R4 pin2 input", 192'(pin_oe), 192'(0));
    do_write(10'h128, 32'h8000_0001);
    check("R4 oe5",  192'(pin_oe),  192'(94'(1) << 5));
    check("R4 out5", 192'(pin_out), 192'(94'(1) << 5));
    do_write(10'h128, 32'h8000_0000);
    check("R4 native", 192'(pin_oe), 192'(0));
    do_write(10'h128, 32'h0000_0001);
    check("R4 oe low lvl", 192'(pin_oe),  192'(94'(1) << 5));
    check("R4 out low",    192'(pin_out), 192'(0));

    // R5 synchronised level, gated by sense disable
    do_write(10'h13C, 32'h0);
    @(negedge clk); pin_in[7] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    do_read(10'h138, d);
    check("R5 lvl high", 192'(d), 192'(32'h4000_0004));
    do_write(10'h13C, 32'h4);
    do_read(10'h138, d);
    check("R5 sense off", 192'(d), 192'(32'h0000_0004));

    // R6 bit 30 not writable, RMW preserves
    do_write(10'h13C, 32'h0);
    do_write(10'h138, 32'h0000_0000);
    do_read(10'h138, d);
    check("R6 clear keeps lvl", 192'(d), 192'(32'h4000_0000));
    do_write(10'h138, d);
    do_read(10'h138, d);
    check("R6 rmw", 192'(d), 192'(32'h4000_0000));
    @(negedge clk); pin_in[7] = 1'b0;
    do_write(10'h138, 32'h4000_0000);
    @(negedge clk);
    @(negedge clk);
    do_read(10'h138, d);
    check("R6 write1 ignored", 192'(d), 192'(32'h0));

    // R9 read data held across idle and writes
    do_read(10'h004, d);
    repeat (3) @(negedge clk);
    do_write(10'h07C, 32'h0);
    check("R9 hold", 192'(rd_data), 192'(32'hDEAD_BEEF));
    check("R7 cleared", 192'(irq_sel), 192'(0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule